// File: doc/BRIEF.md
# Flash Card Sector Transfer Sequencer

This block moves a single 512-byte sector between a local byte buffer and a flash memory card that exposes its ATA-style command registers as a memory-mapped, byte-wide register file. A one-cycle start pulse, together with a direction select and a 28-bit logical block address, begins an operation. The block first checks the address against a supplied sector limit. It then waits for the card to report idle and ready, and programs the count, address and head registers. Next it issues the read or write command, waits for the card to request data, and streams 256 even/odd byte pairs through the data ports.

Read bytes leave the block on a valid/ready output stream, and write bytes arrive on a valid/ready input stream. Every wait loop is guarded by a programmable limit. Each operation ends with a single-cycle completion pulse, an error flag and a small error code.

Top module: `cf_sector_seq`

## Requirements
- R1: When start arrives with `lba` not strictly below `max_sector`, done rises on the next clock edge with error code 1, and no bus read or write is issued.
- R2: Before the command, the block reads the status register at offset 7 once per cycle. Status bits from MSB to LSB are busy, ready, write fault, seek complete, data request, corrected, index, error. The block proceeds only when bit 0 is clear and status AND F0h equals 50h. A set bit 0 ends the operation with code 2.
- R3: The setup writes go to consecutive cycles in this order: offset 2 = 01h, offset 3 = LBA[7:0], offset 4 = LBA[15:8], offset 5 = LBA[23:16], offset 6 = E0h OR LBA[27:24], and then offset 7 = 20h for a read or 30h for a write.
- R4: After the command, the block polls offset 7 until status AND F8h equals 58h. A set bit 0 during this wait ends the operation with code 2.
- R5: In a read, the block issues 256 pairs of byte reads, offset 8 first and then offset 9. It delivers the 512 bytes in order on the output stream, and each byte waits for `dst_ready`.
- R6: In a write, the block takes 512 bytes in order from the input stream. Each accepted byte goes out as a bus write on the same cycle, to offset 8 for even bytes and offset 9 for odd bytes.
- R7: Before each byte pair, and in every status poll, the block samples `card_present`. If the card is absent, the operation ends with code 3. Before each pair, a low `card_ready` stalls the block with no bus cycle, and the pair starts only on the cycle after `card_ready` was seen high.
- R8: A wait loop ends the operation with code 4 after `tmo_limit` consecutive unsatisfied polls (`tmo_limit` must be at least 1).
- R9: `done` is high for exactly one cycle per operation. At that point `error` is high exactly when `err_code` is nonzero. A successful operation reports code 0.
- R10: No bus strobe occurs while the block is idle, and `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| wr_mode | input | 1 | 1 = write sector, 0 = read sector |
| lba | input | 28 | Logical block address |
| max_sector | input | 28 | Number of sectors on the card |
| tmo_limit | input | TO_W | Unsatisfied polls allowed per wait |
| card_present | input | 1 | Card detected in the slot |
| card_ready | input | 1 | Card can accept the next data pair |
| bus_addr | output | 4 | Register offset |
| bus_wdata | output | 8 | Bus write data |
| bus_rd | output | 1 | Bus read strobe (data sampled in the same cycle) |
| bus_wr | output | 1 | Bus write strobe |
| bus_rdata | input | 8 | Bus read data |
| src_data | input | 8 | Write-stream byte |
| src_valid | input | 1 | Write-stream byte available |
| src_ready | output | 1 | Write-stream byte accepted |
| dst_data | output | 8 | Read-stream byte |
| dst_valid | output | 1 | Read-stream byte available |
| dst_ready | input | 1 | Read-stream consumer ready |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Operation failed |
| err_code | output | 3 | 0 ok, 1 range, 2 card error, 3 card absent, 4 timeout |

## Verification
The hardest states to reach are a card that disappears partway through a sector and a card that holds a data pair back. From the ports, these look like an ordinary transfer until a particular pair boundary.

The bench's card model ties `card_present` to its own count of data bytes moved, so the card vanishes after an exact number of pairs. It also drives `card_ready` from a free-running cycle pattern, which throttles pairs at varying points in the sector. The model records whether any even-byte read followed a cycle in which ready was low.

The status sequence is scripted in the same way, with a chosen number of busy replies before and after the command. This lets the poll counts, timeout limits and error bits be swept against exact expected read counts.

// File: rtl/cf_sector_seq.sv
module cf_sector_seq #(
  parameter int PAIRS = 256,
  parameter int TO_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wr_mode,
  input  logic [27:0]     lba,
  input  logic [27:0]     max_sector,
  input  logic [TO_W-1:0] tmo_limit,
  input  logic            card_present,
  input  logic            card_ready,
  output logic [3:0]      bus_addr,
  output logic [7:0]      bus_wdata,
  output logic            bus_rd,
  output logic            bus_wr,
  input  logic [7:0]      bus_rdata,
  input  logic [7:0]      src_data,
  input  logic            src_valid,
  output logic            src_ready,
  output logic [7:0]      dst_data,
  output logic            dst_valid,
  input  logic            dst_ready,
  output logic            done,
  output logic            error,
  output logic [2:0]      err_code
);
  localparam int PW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [2:0] E_OK = 3'd0, E_RANGE = 3'd1, E_DEV = 3'd2, E_GONE = 3'd3, E_TMO = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SET, S_DRQ, S_CHK, S_XFER, S_HOLD} st_t;
  st_t st;

  logic            wr_q, odd;
  logic [27:0]     lba_q;
  logic [2:0]      idx;
  logic [PW-1:0]   pair;
  logic [TO_W-1:0] cnt;
  logic [7:0]      rbyte, set_d;
  logic [3:0]      set_a;
  logic            fin;
  logic [2:0]      fin_code;

  wire poll      = (st == S_PRE) || (st == S_DRQ) || (st == S_CHK);
  wire dev_err   = ((st == S_PRE) || (st == S_DRQ)) && bus_rdata[0];
  wire sat       = (st == S_PRE) ? ((bus_rdata & 8'hF0) == 8'h50) :
                   (st == S_DRQ) ? ((bus_rdata & 8'hF8) == 8'h58) : card_ready;
  wire tmo       = ({1'b0, cnt} + 1'b1) == {1'b0, tmo_limit};
  wire last_pair = pair == PW'(PAIRS - 1);
  wire byte_done = (st == S_XFER && wr_q && src_valid) || (st == S_HOLD && dst_ready);

  always_comb begin
    case (idx)
      3'd0:    begin set_a = 4'd2; set_d = 8'h01; end
      3'd1:    begin set_a = 4'd3; set_d = lba_q[7:0]; end
      3'd2:    begin set_a = 4'd4; set_d = lba_q[15:8]; end
      3'd3:    begin set_a = 4'd5; set_d = lba_q[23:16]; end
      3'd4:    begin set_a = 4'd6; set_d = {4'hE, lba_q[27:24]}; end
      default: begin set_a = 4'd7; set_d = wr_q ? 8'h30 : 8'h20; end
    endcase
  end

  assign bus_rd    = (st == S_PRE) || (st == S_DRQ) || (st == S_XFER && !wr_q);
  assign bus_wr    = (st == S_SET) || (st == S_XFER && wr_q && src_valid);
  assign bus_addr  = (st == S_PRE || st == S_DRQ) ? 4'd7 :
                     (st == S_SET) ? set_a : (st == S_XFER) ? {3'b100, odd} : 4'd0;
  assign bus_wdata = (st == S_SET) ? set_d : (st == S_XFER) ? src_data : 8'h00;
  assign src_ready = (st == S_XFER) && wr_q;
  assign dst_valid = (st == S_HOLD);
  assign dst_data  = rbyte;

  always_comb begin
    fin = 1'b0;
    fin_code = E_OK;
    if (st == S_IDLE && start && !(lba < max_sector)) begin
      fin = 1'b1; fin_code = E_RANGE;
    end else if (poll) begin
      if (!card_present)   begin fin = 1'b1; fin_code = E_GONE; end
      else if (dev_err)    begin fin = 1'b1; fin_code = E_DEV; end
      else if (!sat && tmo) begin fin = 1'b1; fin_code = E_TMO; end
    end else if (byte_done && odd && last_pair) begin
      fin = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wr_q <= 1'b0; lba_q <= '0; idx <= '0; pair <= '0; odd <= 1'b0;
      cnt <= '0; rbyte <= '0; done <= 1'b0; error <= 1'b0; err_code <= E_OK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          wr_q <= wr_mode; lba_q <= lba; cnt <= '0; error <= 1'b0; err_code <= E_OK;
          st <= S_PRE;
        end
        S_PRE, S_DRQ, S_CHK:
          if (sat) begin
            cnt <= '0;
            if (st == S_PRE)      begin st <= S_SET; idx <= '0; end
            else if (st == S_DRQ) begin st <= S_CHK; pair <= '0; odd <= 1'b0; end
            else                  st <= S_XFER;
          end else cnt <= cnt + 1'b1;
        S_SET: begin
          idx <= idx + 1'b1;
          if (idx == 3'd5) st <= S_DRQ;
        end
        S_XFER: if (!wr_q) begin rbyte <= bus_rdata; st <= S_HOLD; end
        default: ;
      endcase
      if (byte_done) begin
        if (!odd) begin odd <= 1'b1; st <= S_XFER; end
        else begin odd <= 1'b0; pair <= pair + 1'b1; st <= S_CHK; end
      end
      if (fin) begin
        done <= 1'b1; error <= (fin_code != E_OK); err_code <= fin_code; st <= S_IDLE;
      end
    end
  end

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!bus_rd && !bus_wr));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (error == (err_code != 3'd0)));
  a_r3_cmd_after_head: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd7) |-> $past(bus_wr && bus_addr == 4'd6));
  a_r1_range_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !(lba < max_sector)) |=> (done && err_code == 3'd1 && !bus_rd && !bus_wr));
  a_r7_pair_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER && !odd && $past(st) == S_CHK) |-> $past(card_ready && card_present));
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && tmo_limit != '0 && $stable(tmo_limit)) |-> (cnt < tmo_limit));
endmodule

// File: tb/tb_cf_sector_seq.sv
module tb_cf_sector_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, wr_mode = 0;
  logic [27:0] lba = 0, max_sector = 0;
  logic [15:0] tmo_limit = 16'd10;
  logic card_present, card_ready;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, src_data, dst_data;
  logic bus_rd, bus_wr, src_valid, src_ready, dst_valid, dst_ready, done, error;
  logic [2:0] err_code;

  cf_sector_seq #(.PAIRS(256), .TO_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode), .lba(lba),
    .max_sector(max_sector), .tmo_limit(tmo_limit), .card_present(card_present),
    .card_ready(card_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .src_data(src_data),
    .src_valid(src_valid), .src_ready(src_ready), .dst_data(dst_data),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .done(done), .error(error),
    .err_code(err_code));

  int checks = 0, errors = 0;
  int pre_busy = 0, drq_busy = 0, gone_after = -1;
  bit pre_err = 0, drq_err = 0, ready_stall = 0, ready_dead = 0, src_stall = 0, dst_stall = 0;
  logic [7:0] seed = 8'h00;
  logic model_clr = 1'b1;

  bit cmd_seen, prev_ready;
  int pre_reads, drq_reads, rd_idx, w_idx, src_idx, dst_idx, dst_bad, wbad, order_bad, early, bus_cnt, wcount;
  logic [3:0] wlog_a [6];
  logic [7:0] wlog_d [6];
  logic [31:0] cyc = 0;

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 37) + s;
  endfunction

  assign card_present = !(gone_after >= 0 && (rd_idx + w_idx) >= gone_after);
  assign card_ready   = !(ready_dead && cmd_seen) && !(ready_stall && cyc[2:0] < 3'd3);
  assign src_data     = pat(src_idx, seed);
  assign src_valid    = !(src_stall && cyc[1:0] == 2'd0);
  assign dst_ready    = !(dst_stall && cyc[1:0] == 2'd1);

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == 4'd7) begin
      if (!cmd_seen) bus_rdata = (pre_reads < pre_busy) ? 8'h90 : (pre_err ? 8'h51 : 8'h50);
      else           bus_rdata = (drq_reads < drq_busy) ? 8'hD0 : (drq_err ? 8'h59 : 8'h58);
    end else if (bus_addr == 4'd8 || bus_addr == 4'd9) bus_rdata = pat(rd_idx, seed);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (model_clr) begin
      cmd_seen <= 0; prev_ready <= 1; pre_reads <= 0; drq_reads <= 0; rd_idx <= 0; w_idx <= 0;
      src_idx <= 0; dst_idx <= 0; dst_bad <= 0; wbad <= 0; order_bad <= 0; early <= 0;
      bus_cnt <= 0; wcount <= 0;
    end else begin
      prev_ready <= card_ready;
      if (bus_rd || bus_wr) bus_cnt <= bus_cnt + 1;
      if (bus_rd && bus_addr == 4'd7) begin
        if (!cmd_seen) pre_reads <= pre_reads + 1; else drq_reads <= drq_reads + 1;
      end
      if (bus_wr && bus_addr >= 4'd2 && bus_addr <= 4'd7) begin
        if (wcount < 6) begin wlog_a[wcount] <= bus_addr; wlog_d[wcount] <= bus_wdata; end
        wcount <= wcount + 1;
        if (bus_addr == 4'd7) cmd_seen <= 1;
      end
      if (bus_rd && (bus_addr == 4'd8 || bus_addr == 4'd9)) begin
        if (bus_addr != (4'd8 + 4'(rd_idx % 2))) order_bad <= order_bad + 1;
        if (rd_idx % 2 == 0 && !prev_ready) early <= early + 1;
        rd_idx <= rd_idx + 1;
      end
      if (bus_wr && (bus_addr == 4'd8 || bus_addr == 4'd9)) begin
        if (bus_addr != (4'd8 + 4'(w_idx % 2))) order_bad <= order_bad + 1;
        if (bus_wdata != pat(w_idx, seed)) wbad <= wbad + 1;
        w_idx <= w_idx + 1;
      end
      if (src_valid && src_ready) src_idx <= src_idx + 1;
      if (dst_valid && dst_ready) begin
        if (dst_data != pat(dst_idx, seed)) dst_bad <= dst_bad + 1;
        dst_idx <= dst_idx + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int log_bad(input bit wr, input logic [27:0] l);
    logic [3:0] ea [6];
    logic [7:0] ed [6];
    int n = 0;
    ea = '{4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7};
    ed = '{8'h01, l[7:0], l[15:8], l[23:16], {4'hE, l[27:24]}, wr ? 8'h30 : 8'h20};
    if (wcount != 6) n++;
    for (int i = 0; i < 6; i++) if (wlog_a[i] != ea[i] || wlog_d[i] != ed[i]) n++;
    return n;
  endfunction

  task automatic run_op(input bit wr, input logic [27:0] l, input logic [27:0] mx,
                        input logic [15:0] lim, output int code, output int cycles);
    @(negedge clk) model_clr = 1;
    @(negedge clk) model_clr = 0;
    wr_mode = wr; lba = l; max_sector = mx; tmo_limit = lim; start = 1;
    @(negedge clk) start = 0;
    cycles = 1;
    while (!done && cycles < 20000) begin @(negedge clk); cycles++; end
    chk("R9 done seen", int'(done), 1);
    code = int'(err_code);
    chk("R9 error flag matches code", int'(error), int'(err_code != 3'd0));
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
  endtask

  task automatic clear_cfg();
    pre_busy = 0; drq_busy = 0; gone_after = -1; pre_err = 0; drq_err = 0;
    ready_stall = 0; ready_dead = 0; src_stall = 0; dst_stall = 0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int code, cyc_n;
    logic [27:0] l;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset error", int'(error), 0);
    chk("R10 reset strobes", int'(bus_rd | bus_wr), 0);

    // R1: range sweep around the limit
    begin
      logic [27:0] mxs [5];
      logic [27:0] ls [5];
      mxs = '{28'd100, 28'd100, 28'd0, 28'hFFFFFFF, 28'd5};
      ls  = '{28'd100, 28'd101, 28'd0, 28'hFFFFFFF, 28'hFFFFFFF};
      for (int i = 0; i < 5; i++) begin
        clear_cfg();
        run_op(i[0], ls[i], mxs[i], 16'd10, code, cyc_n);
        chk("R1 range code", code, 1);
        chk("R1 done latency", cyc_n, 1);
        chk("R1 no bus cycles", bus_cnt, 0);
      end
    end

    // R2 R4 R5 R7: read sweep over busy counts before and after the command
    for (int pb = 0; pb < 4; pb++) begin
      for (int db = 0; db < 4; db++) begin
        clear_cfg();
        pre_busy = pb; drq_busy = db; seed = 8'(pb * 16 + db);
        dst_stall = (db % 2 == 1); ready_stall = (pb % 2 == 1);
        l = 28'h0A5C3E1 + 28'(pb * 4099 + db * 257);
        run_op(0, l, l + 28'd1, 16'd10, code, cyc_n);
        chk("R9 read ok code", code, 0);
        chk("R2 pre polls", pre_reads, pb + 1);
        chk("R4 drq polls", drq_reads, db + 1);
        chk("R3 read setup log", log_bad(0, l), 0);
        chk("R5 bytes read", rd_idx, 512);
        chk("R5 bytes delivered", dst_idx, 512);
        chk("R5 data order", dst_bad, 0);
        chk("R5 even then odd", order_bad, 0);
        chk("R7 pair waits for ready", early, 0);
      end
    end

    // R6: write sector with and without input stalls
    for (int k = 0; k < 4; k++) begin
      clear_cfg();
      src_stall = k[0]; pre_busy = k; drq_busy = 3 - k; seed = 8'(200 + k);
      l = 28'hFEDCBA9 - 28'(k * 77);
      run_op(1, l, 28'hFFFFFFF, 16'd10, code, cyc_n);
      chk("R6 write ok code", code, 0);
      chk("R3 write setup log", log_bad(1, l), 0);
      chk("R6 bytes written", w_idx, 512);
      chk("R6 bytes taken", src_idx, 512);
      chk("R6 write data", wbad, 0);
      chk("R6 even then odd", order_bad, 0);
    end

    clear_cfg(); pre_err = 1;
    run_op(0, 28'd7, 28'd8, 16'd10, code, cyc_n);
    chk("R2 error bit before command", code, 2);
    chk("R2 no setup writes", wcount, 0);

    clear_cfg(); drq_err = 1; drq_busy = 2;
    run_op(0, 28'd7, 28'd8, 16'd10, code, cyc_n);
    chk("R4 error bit after command", code, 2);
    chk("R4 no data cycles", rd_idx, 0);

    clear_cfg(); pre_busy = 1000;
    run_op(0, 28'd1, 28'd9, 16'd5, code, cyc_n);
    chk("R8 pre timeout code", code, 4);
    chk("R8 pre timeout polls", pre_reads, 5);
    chk("R8 no setup after timeout", wcount, 0);

    clear_cfg(); drq_busy = 1000;
    run_op(1, 28'd1, 28'd9, 16'd7, code, cyc_n);
    chk("R8 drq timeout code", code, 4);
    chk("R8 drq timeout polls", drq_reads, 7);

    clear_cfg(); ready_dead = 1;
    run_op(0, 28'd1, 28'd9, 16'd4, code, cyc_n);
    chk("R8 ready timeout code", code, 4);
    chk("R7 no data while not ready", rd_idx, 0);

    clear_cfg(); gone_after = 10;
    run_op(0, 28'd3, 28'd9, 16'd10, code, cyc_n);
    chk("R7 card removed code", code, 3);
    chk("R7 bytes before removal", rd_idx, 10);

    clear_cfg(); gone_after = 0;
    run_op(1, 28'd3, 28'd9, 16'd10, code, cyc_n);
    chk("R7 card absent code", code, 3);
    chk("R7 absent no setup", wcount, 0);

    clear_cfg();
    @(negedge clk);
    chk("R10 idle strobes", int'(bus_rd | bus_wr), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule